// File: doc/BRIEF.md
# Tagged Message Buffer with Associative Lookup

This block holds incoming messages on the receive side of a core until the processor asks for them. Each stored message carries a sender identifier, a small message-kind code and a data word. Messages arrive on a write port with a valid/ready handshake and land in any free slot. The processor does not pop them in arrival order. It presents a lookup key made of a sender value and a kind value, and each half of the key can be switched to "match anything" on its own.

When one or more stored messages satisfy the key, the one that was written earliest is returned, together with its sender and kind, in a registered response one cycle later. That slot is released in the same step. When nothing matches, the response reports a miss and the stored contents stay as they were. The block also reports when every slot is occupied, and how many slots are in use.

Top module: `msg_match_buf`

## Requirements
- R1: A write with `wr_valid` high and `wr_ready` high at a rising edge stores the message, and `occupancy` is one higher after that edge.
- R2: A lookup presented with `lk_valid` high at a rising edge produces `rsp_valid` high for exactly the following cycle. `rsp_valid` is low after any cycle without a lookup.
- R3: With `lk_src_any` low, only entries whose sender equals `lk_src` match. With `lk_src_any` high, the sender is ignored.
- R4: With `lk_kind_any` low, only entries whose kind equals `lk_kind` match. With `lk_kind_any` high, the kind is ignored. The two wildcards act independently.
- R5: On a hit, `rsp_hit` is 1 and `rsp_src`, `rsp_kind` and `rsp_data` carry the stored message. The entry is freed, `occupancy` drops by one, and a repeat of the same lookup no longer returns that message.
- R6: On a miss, `rsp_hit` is 0, `rsp_src`, `rsp_kind` and `rsp_data` are all zero, and `occupancy` and the stored contents do not change.
- R7: When several entries match, the response returns the one written earliest among them. This holds regardless of removals in between.
- R8: When all `DEPTH` slots are in use, `full` is 1 and `wr_ready` is 0. A write offered in that state is dropped and never appears in a later response.
- R9: A write and a hitting lookup in the same cycle both take effect, so `occupancy` is unchanged. The lookup searches only entries stored before that edge, so it cannot return the message written in the same cycle.
- R10: After reset, `occupancy` is 0, `full` is 0, `wr_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Incoming message is offered |
| wr_ready | output | 1 | A free slot exists |
| wr_src | input | SRC_W | Sender of the incoming message |
| wr_kind | input | KIND_W | Kind code of the incoming message |
| wr_data | input | DATA_W | Payload of the incoming message |
| lk_valid | input | 1 | Lookup request |
| lk_src | input | SRC_W | Sender key |
| lk_src_any | input | 1 | Ignore the sender key |
| lk_kind | input | KIND_W | Kind key |
| lk_kind_any | input | 1 | Ignore the kind key |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response found a message |
| rsp_src | output | SRC_W | Sender of the returned message |
| rsp_kind | output | KIND_W | Kind of the returned message |
| rsp_data | output | DATA_W | Payload of the returned message |
| full | output | 1 | All slots occupied |
| occupancy | output | $clog2(DEPTH+1) | Number of occupied slots |

## Verification
Every result of this block appears one edge after its cause. The lookup response, the freed slot, the new occupancy and the change in `full`/`wr_ready` all become visible after the rising edge that accepted the write or lookup. The bench drives inputs on the falling edge and samples at the next falling edge, which is half a period after the edge that registered the result. Same-cycle write/lookup cases are checked at that same point, and then again by a further lookup to confirm which message remained.

// File: rtl/msg_match_pkg.sv
package msg_match_pkg;

    // Index width that stays at least one bit for a single-entry store.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/msg_slot_cmp.sv
module msg_slot_cmp #(
    parameter int SRC_W  = 4,
    parameter int KIND_W = 2
) (
    input  logic              slot_vld,
    input  logic [SRC_W-1:0]  slot_src,
    input  logic [KIND_W-1:0] slot_kind,
    input  logic [SRC_W-1:0]  key_src,
    input  logic              key_src_any,
    input  logic [KIND_W-1:0] key_kind,
    input  logic              key_kind_any,
    output logic              slot_hit
);
    logic src_ok;
    logic kind_ok;

    always_comb begin
        src_ok   = key_src_any  || (slot_src  == key_src);
        kind_ok  = key_kind_any || (slot_kind == key_kind);
        slot_hit = slot_vld && src_ok && kind_ok;
    end
endmodule

// File: rtl/msg_oldest_pick.sv
module msg_oldest_pick #(
    parameter int DEPTH  = 8,
    parameter int RANK_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic [DEPTH-1:0]             match,
    input  logic [DEPTH-1:0][RANK_W-1:0] rank,
    output logic                         found,
    output logic [IDX_W-1:0]             idx
);
    logic [RANK_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i] && (!found || rank[i] < best)) begin
                found = 1'b1;
                best  = rank[i];
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/msg_free_pick.sv
module msg_free_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] vld,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/msg_match_buf.sv
module msg_match_buf
    import msg_match_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SRC_W  = 4,
    parameter int KIND_W = 2,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_valid,
    output logic                         wr_ready,
    input  logic [SRC_W-1:0]             wr_src,
    input  logic [KIND_W-1:0]            wr_kind,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         lk_valid,
    input  logic [SRC_W-1:0]             lk_src,
    input  logic                         lk_src_any,
    input  logic [KIND_W-1:0]            lk_kind,
    input  logic                         lk_kind_any,
    output logic                         rsp_valid,
    output logic                         rsp_hit,
    output logic [SRC_W-1:0]             rsp_src,
    output logic [KIND_W-1:0]            rsp_kind,
    output logic [DATA_W-1:0]            rsp_data,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   occupancy
);
    localparam int IDX_W  = idx_bits(DEPTH);
    localparam int RANK_W = idx_bits(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]              vld;
        logic [DEPTH-1:0][SRC_W-1:0]   src;
        logic [DEPTH-1:0][KIND_W-1:0]  kind;
        logic [DEPTH-1:0][DATA_W-1:0]  data;
        logic [DEPTH-1:0][RANK_W-1:0]  rank;   // 0 = earliest written
        logic [CNT_W-1:0]              cnt;
        logic                          rsp_valid;
        logic                          rsp_hit;
        logic [SRC_W-1:0]              rsp_src;
        logic [KIND_W-1:0]             rsp_kind;
        logic [DATA_W-1:0]             rsp_data;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0] match_vec;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic             is_full;
    logic             wr_fire;
    logic             lk_hit;

    // One comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        msg_slot_cmp #(.SRC_W(SRC_W), .KIND_W(KIND_W)) u_cmp (
            .slot_vld     (st_q.vld[g]),
            .slot_src     (st_q.src[g]),
            .slot_kind    (st_q.kind[g]),
            .key_src      (lk_src),
            .key_src_any  (lk_src_any),
            .key_kind     (lk_kind),
            .key_kind_any (lk_kind_any),
            .slot_hit     (match_vec[g])
        );
    end

    msg_oldest_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick (
        .match (match_vec),
        .rank  (st_q.rank),
        .found (pick_found),
        .idx   (pick_idx)
    );

    msg_free_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_free (
        .vld      (st_q.vld),
        .any_free (free_any),
        .idx      (free_idx)
    );

    always_comb begin
        st_d    = st_q;
        is_full = (st_q.cnt == CNT_W'(DEPTH));
        wr_fire = wr_valid && !is_full && free_any;
        lk_hit  = lk_valid && pick_found;

        st_d.rsp_valid = lk_valid;
        st_d.rsp_hit   = lk_hit;
        st_d.rsp_src   = '0;
        st_d.rsp_kind  = '0;
        st_d.rsp_data  = '0;

        if (lk_hit) begin
            st_d.rsp_src  = st_q.src[pick_idx];
            st_d.rsp_kind = st_q.kind[pick_idx];
            st_d.rsp_data = st_q.data[pick_idx];
            st_d.vld[pick_idx] = 1'b0;
            // Close the gap in the age order left by the removed entry
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.vld[i] && st_q.rank[i] > st_q.rank[pick_idx]) begin
                    st_d.rank[i] = st_q.rank[i] - RANK_W'(1);
                end
            end
        end

        if (wr_fire) begin
            st_d.vld[free_idx]  = 1'b1;
            st_d.src[free_idx]  = wr_src;
            st_d.kind[free_idx] = wr_kind;
            st_d.data[free_idx] = wr_data;
            st_d.rank[free_idx] = RANK_W'(st_q.cnt - CNT_W'(lk_hit));
        end

        st_d.cnt = st_q.cnt + CNT_W'(wr_fire) - CNT_W'(lk_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ready  = !is_full;
    assign full      = is_full;
    assign occupancy = st_q.cnt;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_src   = st_q.rsp_src;
    assign rsp_kind  = st_q.rsp_kind;
    assign rsp_data  = st_q.rsp_data;

    // R1: an accepted write with no lookup grows the occupancy by one
    a_r1_write_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !lk_valid) |=> occupancy == $past(occupancy) + 1'b1);

    // R2: a lookup is answered on the next cycle
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2: no response without a preceding lookup
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R5: a hit with no write shrinks occupancy by one
    a_r5_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !(wr_valid && wr_ready)) |=>
            (rsp_hit ? occupancy == $past(occupancy) - 1'b1
                     : occupancy == $past(occupancy)));

    // R6: a miss returns zeroed fields
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && rsp_src == '0 && rsp_kind == '0));

    // R8: occupancy never exceeds the slot count and full blocks writes
    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_ready);

    // R9: a write and a hit together leave occupancy unchanged
    a_r9_swap_count: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && wr_valid && wr_ready) |=>
            (rsp_hit ? occupancy == $past(occupancy)
                     : occupancy == $past(occupancy) + 1'b1));
endmodule

// File: tb/tb_msg_match_buf.sv
module tb_msg_match_buf;
    localparam int DEPTH = 8, SRC_W = 4, KIND_W = 2, DATA_W = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, wr_ready;
    logic [SRC_W-1:0] wr_src = '0;
    logic [KIND_W-1:0] wr_kind = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic lk_valid = 1'b0, lk_src_any = 1'b0, lk_kind_any = 1'b0;
    logic [SRC_W-1:0] lk_src = '0;
    logic [KIND_W-1:0] lk_kind = '0;
    logic rsp_valid, rsp_hit, full;
    logic [SRC_W-1:0] rsp_src;
    logic [KIND_W-1:0] rsp_kind;
    logic [DATA_W-1:0] rsp_data;
    logic [CNT_W-1:0] occupancy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    msg_match_buf #(.DEPTH(DEPTH), .SRC_W(SRC_W), .KIND_W(KIND_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_src(wr_src), .wr_kind(wr_kind), .wr_data(wr_data),
        .lk_valid(lk_valid), .lk_src(lk_src), .lk_src_any(lk_src_any),
        .lk_kind(lk_kind), .lk_kind_any(lk_kind_any),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_src(rsp_src),
        .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .full(full), .occupancy(occupancy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle starting at a falling edge; returns at the next falling edge
    task automatic cyc(input bit wv, input int ws, input int wk, input int wd,
                       input bit lv, input int ls, input bit lsa, input int lk, input bit lka);
        wr_valid = wv; wr_src = SRC_W'(ws); wr_kind = KIND_W'(wk); wr_data = DATA_W'(wd);
        lk_valid = lv; lk_src = SRC_W'(ls); lk_src_any = lsa; lk_kind = KIND_W'(lk); lk_kind_any = lka;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        lk_valid = 1'b0;
    endtask

    task automatic wr(input int s, input int k, input int d);
        cyc(1, s, k, d, 0, 0, 0, 0, 0);
    endtask

    task automatic lk(input int s, input bit sa, input int k, input bit ka);
        cyc(0, 0, 0, 0, 1, s, sa, k, ka);
    endtask

    task automatic expect_hit(input string req, input int s, input int k, input int d);
        check({req, " rsp_valid"}, int'(rsp_valid), 1);
        check({req, " rsp_hit"}, int'(rsp_hit), 1);
        check({req, " rsp_src"}, int'(rsp_src), s);
        check({req, " rsp_kind"}, int'(rsp_kind), k);
        check({req, " rsp_data"}, int'(rsp_data), d);
    endtask

    task automatic expect_miss(input string req);
        check({req, " rsp_valid"}, int'(rsp_valid), 1);
        check({req, " rsp_hit"}, int'(rsp_hit), 0);
        check({req, " rsp_data zero"}, int'(rsp_data), 0);
    endtask

    task automatic t_reset();
        check("R10 occupancy", int'(occupancy), 0);
        check("R10 full", int'(full), 0);
        check("R10 wr_ready", int'(wr_ready), 1);
        check("R10 rsp_valid", int'(rsp_valid), 0);
    endtask

    task automatic t_keys();
        wr(3, 1, 16'hA1);
        check("R1 occupancy after write", int'(occupancy), 1);
        check("R2 no response after write", int'(rsp_valid), 0);
        wr(5, 2, 16'hB2);
        wr(3, 2, 16'hC3);
        check("R1 occupancy three", int'(occupancy), 3);
        lk(5, 0, 2, 0);
        expect_hit("R3 exact keys", 5, 2, 16'hB2);
        check("R5 occupancy after hit", int'(occupancy), 2);
        lk(5, 0, 2, 0);
        expect_miss("R5 repeat lookup misses");
        check("R6 occupancy after miss", int'(occupancy), 2);
        lk(9, 0, 0, 1);
        expect_miss("R3 unknown sender with kind wildcard");
        lk(0, 1, 2, 0);
        expect_hit("R4 sender wildcard kind exact", 3, 2, 16'hC3);
        lk(3, 0, 0, 1);
        expect_hit("R4 kind wildcard sender exact", 3, 1, 16'hA1);
        check("R5 empty again", int'(occupancy), 0);
        lk(0, 1, 0, 1);
        expect_miss("R6 empty both wildcards");
    endtask

    task automatic t_order();
        wr(7, 0, 10);
        wr(7, 0, 20);
        wr(7, 0, 30);
        lk(0, 1, 0, 1);
        expect_hit("R7 oldest first", 7, 0, 10);
        wr(7, 0, 40);
        lk(7, 0, 0, 0);
        expect_hit("R7 second oldest", 7, 0, 20);
        lk(7, 0, 0, 0);
        expect_hit("R7 third oldest", 7, 0, 30);
        lk(7, 0, 0, 0);
        expect_hit("R7 newest last", 7, 0, 40);
        check("R7 drained", int'(occupancy), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) wr(i, i % 4, 100 + i);
        check("R8 full flag", int'(full), 1);
        check("R8 wr_ready low", int'(wr_ready), 0);
        wr(9, 1, 999);
        check("R8 dropped write keeps count", int'(occupancy), DEPTH);
        lk(2, 0, 2, 0);
        expect_hit("R8 exact hit while full", 2, 2, 102);
        check("R8 ready after free", int'(wr_ready), 1);
        check("R8 full cleared", int'(full), 0);
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 2) continue;
            lk(0, 1, 0, 1);
            expect_hit("R8 drain order", i, i % 4, 100 + i);
        end
        lk(0, 1, 0, 1);
        expect_miss("R8 dropped write never stored");
    endtask

    task automatic t_same_cycle();
        wr(1, 1, 55);
        cyc(1, 1, 1, 66, 1, 1, 0, 1, 0);
        expect_hit("R9 lookup sees older entry", 1, 1, 55);
        check("R9 occupancy unchanged", int'(occupancy), 1);
        cyc(1, 2, 3, 77, 1, 2, 0, 3, 0);
        expect_miss("R9 same-cycle write not visible");
        check("R9 occupancy after miss+write", int'(occupancy), 2);
        lk(1, 0, 1, 0);
        expect_hit("R9 written entry kept", 1, 1, 66);
        lk(2, 0, 3, 0);
        expect_hit("R9 second write kept", 2, 3, 77);
        check("R9 empty", int'(occupancy), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_keys();
        t_order();
        t_full();
        t_same_cycle();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule